// File: doc/BRIEF.md
# Synchronous Configuration Bitstream Streamer

This block sits on the memory side of a configuration link. It reads a stored configuration image out of a synchronous-read memory port and presents it to a loading device over a 16-bit parallel bus, one word per configuration clock. It starts only after a handshake on a shared open-drain ready line. During its own reset period the block pulls this line low. It then releases the line and watches it. When both sides have let go and the line reads high, streaming begins.

The first read address comes from one of two places, selected by a mode input that is sampled in the handshake cycle. In master mode the address is taken from a bus that the loader drives. In slave mode it is taken from static strap inputs. The memory read has one cycle of latency. Because the first read is issued in the handshake cycle itself, the first word appears on the next clock and the words after it follow with no gaps. Streaming ends when the loader raises its done line. A low on the shared ready line, or a new reset, discards the session.

Top module: `cfg_stream_engine`

## Requirements
- R1: While `dq_vld_o` is high, `dq_o` carries one 16-bit image word on every clock.
- R2: For exactly HOLD_CYC cycles after reset deasserts (default 4), counting the cycle in which it deasserts, `rdy_pull_o` is 1 (line pulled low). After that it is 0 (released).
- R3: No memory read is issued and no word is marked valid until the line reads high (`rdy_line_i`=1) while the block has it released. The read of the start address is issued in that same cycle.
- R4: In the handshake cycle the start address is `ldr_addr_i` when `mode_master_i`=1 and `strap_addr_i` when `mode_master_i`=0. Changes to the mode or address inputs after that cycle have no effect on the words being streamed.
- R5: The first valid word is the memory word at the start address. It appears in the cycle right after the handshake cycle.
- R6: Each later word comes from the next address, with no idle cycle between words, and `mem_addr_o` steps by one per cycle. The 24-bit address wraps from FFFFFF to 000000.
- R7: If `done_i` is high in a streaming cycle, the word in that cycle is the last one. From the next cycle on, `dq_vld_o` and `mem_rd_o` stay 0 until a new session starts.
- R8: `dq_oe_o` is 1 only when `oe_i`=1 and a valid word is present. When no valid word is present, `dq_o` is zero.
- R9: A low on the ready line during streaming or after done returns the block to the released waiting state with no reads, and the address counter is discarded. The next handshake starts from a freshly latched start address. Asserting reset returns the block to the pull-low state at once.
- R10: If `done_i` is high and the line reads low in the same streaming cycle, the line-low abort takes priority and the block goes back to waiting, not to the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rdy_line_i | input | 1 | Observed level of the shared open-drain ready line |
| rdy_pull_o | output | 1 | 1 pulls the shared ready line low |
| mode_master_i | input | 1 | 1: start address from the loader bus; 0: from the straps |
| ldr_addr_i | input | 24 | Start address driven by the loader |
| strap_addr_i | input | 24 | Static strap start address |
| done_i | input | 1 | Loader completion indication |
| oe_i | input | 1 | Output enable for the data pad drivers |
| dq_o | output | 16 | Streamed data word |
| dq_oe_o | output | 1 | Drive enable for the data pads (0 means tri-stated) |
| dq_vld_o | output | 1 | Marks a valid word on `dq_o` |
| mem_addr_o | output | 24 | Memory read address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the strobe |

## Verification
Two things can land in the same streaming cycle: the loader raising done and the shared ready line being pulled low. The bench provokes this by setting both in one cycle in the middle of a stream. It then releases the line straight away and checks that a read of the newly selected start address appears in the next cycle. That read can only happen if the block went back to waiting rather than to the stopped state. The other collisions the bench covers are done arriving on a session's last word while the address counter wraps, and the mode and address inputs changing while a stream is running. In each case it compares every word against a memory model that it computes itself.

// File: rtl/cfg_stream_pkg.sv
`timescale 1ns/1ps
package cfg_stream_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_STOP = 2'd3
    } cfg_st_e;
endpackage

// File: rtl/cfg_start_sel.sv
`timescale 1ns/1ps
module cfg_start_sel #(
    parameter int ADDR_W = 24
) (
    input  logic              mode_master_i,
    input  logic [ADDR_W-1:0] ldr_addr_i,
    input  logic [ADDR_W-1:0] strap_addr_i,
    output logic [ADDR_W-1:0] start_o,
    output logic [ADDR_W-1:0] start_nxt_o
);
    always_comb begin
        start_o     = mode_master_i ? ldr_addr_i : strap_addr_i;
        start_nxt_o = start_o + ADDR_W'(1);
    end
endmodule

// File: rtl/cfg_addr_ctr.sv
`timescale 1ns/1ps
module cfg_addr_ctr #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] q_o
);
    logic [ADDR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (load_i) cnt_d = load_val_i;
        else if (inc_i)  cnt_d = cnt_q + ADDR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q_o = cnt_q;
endmodule

// File: rtl/cfg_stream_engine.sv
`timescale 1ns/1ps
module cfg_stream_engine #(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int HOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy_line_i,
    output logic              rdy_pull_o,
    input  logic              mode_master_i,
    input  logic [ADDR_W-1:0] ldr_addr_i,
    input  logic [ADDR_W-1:0] strap_addr_i,
    input  logic              done_i,
    input  logic              oe_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              dq_vld_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    import cfg_stream_pkg::*;

    localparam int HC_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);

    typedef struct packed {
        cfg_st_e         st;
        logic [HC_W-1:0] hold;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] start_addr, start_nxt, ctr_q;
    logic              ctr_clr, ctr_ld, ctr_inc;

    cfg_start_sel #(.ADDR_W(ADDR_W)) u_sel (
        .mode_master_i (mode_master_i),
        .ldr_addr_i    (ldr_addr_i),
        .strap_addr_i  (strap_addr_i),
        .start_o       (start_addr),
        .start_nxt_o   (start_nxt)
    );

    cfg_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (ctr_clr),
        .load_i     (ctr_ld),
        .load_val_i (start_nxt),
        .inc_i      (ctr_inc),
        .q_o        (ctr_q)
    );

    // Next-state logic: the session controller and the memory request.
    always_comb begin
        ctl_d      = ctl_q;
        ctr_clr    = 1'b0;
        ctr_ld     = 1'b0;
        ctr_inc    = 1'b0;
        mem_rd_o   = 1'b0;
        mem_addr_o = ctr_q;
        rdy_pull_o = 1'b0;
        unique case (ctl_q.st)
            ST_HOLD: begin
                rdy_pull_o = 1'b1;
                if (ctl_q.hold == HC_W'(HOLD_CYC - 1)) begin
                    ctl_d.st   = ST_WAIT;
                    ctl_d.hold = '0;
                end else begin
                    ctl_d.hold = ctl_q.hold + HC_W'(1);
                end
            end
            ST_WAIT: begin
                mem_addr_o = start_addr;
                if (rdy_line_i) begin
                    mem_rd_o = 1'b1;      // prefetch the first word
                    ctr_ld   = 1'b1;
                    ctl_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!rdy_line_i) begin    // abort outranks done
                    ctr_clr  = 1'b1;
                    ctl_d.st = ST_WAIT;
                end else if (done_i) begin
                    ctl_d.st = ST_STOP;
                end else begin
                    mem_rd_o = 1'b1;
                    ctr_inc  = 1'b1;
                end
            end
            ST_STOP: begin
                if (!rdy_line_i) begin
                    ctr_clr  = 1'b1;
                    ctl_d.st = ST_WAIT;
                end
            end
            default: ctl_d.st = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_HOLD, hold: '0};
        else        ctl_q <= ctl_d;
    end

    assign dq_vld_o = (ctl_q.st == ST_RUN);
    assign dq_o     = dq_vld_o ? mem_rdata_i : '0;
    assign dq_oe_o  = oe_i & dq_vld_o;
endmodule

// File: rtl/cfg_stream_chk.sv
`timescale 1ns/1ps
module cfg_stream_chk #(
    parameter int ADDR_W   = 24,
    parameter int HOLD_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rdy_line_i,
    input logic              rdy_pull_o,
    input logic              done_i,
    input logic              oe_i,
    input logic              dq_oe_o,
    input logic              dq_vld_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rd_o
);
    localparam int CW = $clog2(HOLD_CYC + 2);
    logic [CW-1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            since_rst <= '0;
        else if (since_rst < CW'(HOLD_CYC))    since_rst <= since_rst + CW'(1);
    end

    AST_HOLD_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(HOLD_CYC)) |-> rdy_pull_o); // R2

    AST_START_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_vld_o && !$past(dq_vld_o)) |-> ($past(mem_rd_o) && $past(rdy_line_i))); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && dq_vld_o && $past(mem_rd_o) && $past(dq_vld_o))
            |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R6

    AST_DONE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_vld_o && done_i) |=> !dq_vld_o); // R7

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> (oe_i && dq_vld_o)); // R8

    AST_LINE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_vld_o && !rdy_line_i) |=> (!dq_vld_o && !rdy_pull_o)); // R9
endmodule

bind cfg_stream_engine cfg_stream_chk #(.ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy_line_i (rdy_line_i),
    .rdy_pull_o (rdy_pull_o),
    .done_i     (done_i),
    .oe_i       (oe_i),
    .dq_oe_o    (dq_oe_o),
    .dq_vld_o   (dq_vld_o),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o)
);

// File: tb/sim_cfg_stream_engine.sv
`timescale 1ns/1ps
module sim_cfg_stream_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ldr_pull = 1'b1;
    logic        rdy_line;
    logic        rdy_pull;
    logic        mode = 1'b0;
    logic [23:0] ldr_addr = '0;
    logic [23:0] strap_addr = '0;
    logic        done = 1'b0;
    logic        oe = 1'b0;
    logic [15:0] dq;
    logic        dq_oe, dq_vld;
    logic [23:0] mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign rdy_line = !(ldr_pull || rdy_pull);   // wired-AND with pull-up

    cfg_stream_engine u0 (
        .clk(clk), .rst_n(rst_n), .rdy_line_i(rdy_line), .rdy_pull_o(rdy_pull),
        .mode_master_i(mode), .ldr_addr_i(ldr_addr), .strap_addr_i(strap_addr),
        .done_i(done), .oe_i(oe), .dq_o(dq), .dq_oe_o(dq_oe), .dq_vld_o(dq_vld),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata)
    );

    function automatic logic [15:0] img(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h3C5A;
    endfunction

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= img(mem_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    typedef struct packed {
        logic        md;
        logic [23:0] la;
        logic [23:0] sa;
        logic [23:0] exp_start;
        logic [7:0]  nw;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{1'b1, 24'h000100, 24'h00ABCD, 24'h000100, 8'd5},
        '{1'b0, 24'h000200, 24'h00ABCD, 24'h00ABCD, 8'd6},
        '{1'b1, 24'hFFFFFD, 24'h000000, 24'hFFFFFD, 8'd6},
        '{1'b0, 24'h123456, 24'hFFFFFF, 24'hFFFFFF, 8'd3}
    };

    // Expects the block waiting with the loader holding the line low.
    task automatic run_session(input vec_t v);
        mode = v.md; ldr_addr = v.la; strap_addr = v.sa;
        @(negedge clk); ldr_pull = 1'b0; #1;
        chk(mem_rd === 1'b1, "R3", "read in handshake cycle", 32'(mem_rd), 32'd1);
        chk(mem_addr === v.exp_start, "R4", "start address", 32'(mem_addr), 32'(v.exp_start));
        for (int i = 0; i < int'(v.nw); i++) begin
            logic [23:0] a;
            a = v.exp_start + 24'(i);
            @(negedge clk);
            oe = i[0];
            done = (i == int'(v.nw) - 1);
            if (i == 1) begin mode = !v.md; ldr_addr = ~v.la; strap_addr = ~v.sa; end
            #1;
            chk(dq_vld === 1'b1 && dq === img(a), (i == 0) ? "R5" : "R6",
                "streamed word", {15'd0, dq_vld, dq}, {16'd1, img(a)});
            chk(dq_oe === oe, "R8", "pad enable", 32'(dq_oe), 32'(oe));
            if (i < int'(v.nw) - 1)
                chk(mem_rd === 1'b1 && mem_addr === a + 24'd1, "R6", "next read address",
                    32'(mem_addr), 32'(a + 24'd1));
        end
        @(negedge clk); done = 1'b0; oe = 1'b1; #1;
        chk(!dq_vld && !mem_rd, "R7", "stopped after done", {30'd0, dq_vld, mem_rd}, 32'd0);
        chk(dq_oe === 1'b0 && dq === 16'd0, "R8", "idle bus", {15'd0, dq_oe, dq}, 32'd0);
        @(negedge clk); #1;
        chk(!dq_vld && !mem_rd, "R7", "still stopped", {30'd0, dq_vld, mem_rd}, 32'd0);
        ldr_pull = 1'b1;
        @(negedge clk); #1;
        chk(!rdy_pull && !mem_rd, "R9", "back to waiting", {30'd0, rdy_pull, mem_rd}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL R3 watchdog expired: actual %h expected %h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        #1;
        chk(rdy_pull === 1'b1 && dq_vld === 1'b0, "R2", "reset pulls line",
            {30'd0, rdy_pull, dq_vld}, 32'd2);
        chk(dq === 16'd0 && dq_oe === 1'b0, "R8", "reset bus idle", {15'd0, dq_oe, dq}, 32'd0);
        @(negedge clk); rst_n = 1'b1; #1;
        chk(rdy_pull === 1'b1, "R2", "hold cycle 0", 32'(rdy_pull), 32'd1);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk); #1;
            chk(rdy_pull === 1'b1, "R2", "hold cycle", 32'(rdy_pull), 32'd1);
        end
        @(negedge clk); #1;
        chk(rdy_pull === 1'b0, "R2", "released after hold", 32'(rdy_pull), 32'd0);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); #1;
            chk(!mem_rd && !dq_vld, "R3", "no read while line low", {30'd0, mem_rd, dq_vld}, 32'd0);
        end

        // Table of sessions (R1, R4, R5, R6, R7, R8)
        for (int v = 0; v < 4; v++) run_session(VEC[v]);

        // R10: done and line-low abort in the same cycle
        mode = 1'b1; ldr_addr = 24'h000040;
        @(negedge clk); ldr_pull = 1'b0;
        @(negedge clk); #1;
        chk(dq_vld && dq === img(24'h000040), "R1", "first word", 32'(dq), 32'(img(24'h000040)));
        @(negedge clk); done = 1'b1; ldr_pull = 1'b1; #1;
        chk(dq_vld && dq === img(24'h000041), "R1", "second word", 32'(dq), 32'(img(24'h000041)));
        @(negedge clk); done = 1'b0; ldr_pull = 1'b0; mode = 1'b0; strap_addr = 24'h000777; #1;
        chk(mem_rd === 1'b1 && !rdy_pull, "R10", "abort wins over done",
            {30'd0, mem_rd, rdy_pull}, 32'd2);
        chk(mem_addr === 24'h000777, "R9", "fresh start address", 32'(mem_addr), 32'h777);
        @(negedge clk); done = 1'b1; #1;
        chk(dq_vld && dq === img(24'h000777), "R9", "restart word", 32'(dq), 32'(img(24'h000777)));
        @(negedge clk); done = 1'b0; #1;
        chk(!dq_vld, "R7", "done ends restart", 32'(dq_vld), 32'd0);

        // R9: reset during a stream
        ldr_pull = 1'b1;
        @(negedge clk); ldr_pull = 1'b0; mode = 1'b1; ldr_addr = 24'h000010;
        @(negedge clk); #1;
        chk(dq_vld === 1'b1, "R1", "stream before reset", 32'(dq_vld), 32'd1);
        rst_n = 1'b0; #1;
        chk(rdy_pull === 1'b1 && !dq_vld && !mem_rd, "R9", "reset returns to hold",
            {29'd0, rdy_pull, dq_vld, mem_rd}, 32'd4);

        finish_run();
    end
endmodule